// File: doc/BRIEF.md
# Two-Client Tournament Arbitration Cell

This block is one node of a tree-shaped arbiter. On its lower side it serves two clients, each over its own four-phase request/grant handshake that the client starts. On its upper side it acts as an ordinary client of a parent node. It raises its own upward request, and it hands out a client grant only while that upward handshake is won. Inside, a two-way mutual-exclusion stage chooses which waiting client is granted. A tree of these cells forms a knockout bracket. A request must win every round on its path before its client may use the shared resource.

Release follows the early-release discipline by default. When the active client drops its request, the cell lowers that client's grant and raises the other client's grant on the same clock edge. A parameter selects the stricter late-release variant instead. In that variant the two grants are never high together, and handover takes one extra cycle. When both clients become eligible in the same cycle, a fairness bit breaks the tie. That bit always points at the client that was not granted most recently. All inputs are assumed synchronous to the clock. Reset is asserted asynchronously and released through a synchronizer.

Top module: `tourney_cell`

## Requirements
- R1: While reset is low, and for the cycles the reset synchronizer takes to release, gnt_a, gnt_b and up_req are all 0. Asserting reset clears them without waiting for a clock edge.
- R2: When the cell is idle (up_req 0, up_gnt 0) and either client request is 1 before an edge, up_req is 1 after that edge.
- R3: A client grant rises only on an edge before which both up_req and up_gnt were 1. A grant does not rise while up_gnt is 0, or while up_req is 0.
- R4: At no time are both (req_a and gnt_a) and (req_b and gnt_b) true.
- R5: A grant stays high for as long as its request stays high. It falls on the first edge after its request is seen low.
- R6: With LATE_RELEASE=0, when the served client drops its request while the other client is waiting, the old grant falls and the new grant rises on the same edge.
- R7: With LATE_RELEASE=1, gnt_a and gnt_b are never 1 together, and the new grant rises one edge after the old grant falls.
- R8: When both clients become eligible in the same cycle, the one granted is the one not granted most recently. After reset, client A has priority.
- R9: up_req stays 1 while any client request is 1. It falls on the first edge at which up_gnt is 1 and both requests are 0.
- R10: After up_req has fallen, it is not raised again until up_gnt has been seen at 0, even if a client request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released through a synchronizer |
| req_a | input | 1 | Request from client A |
| gnt_a | output | 1 | Grant to client A |
| req_b | input | 1 | Request from client B |
| gnt_b | output | 1 | Grant to client B |
| up_req | output | 1 | Request from the cell to its parent |
| up_gnt | input | 1 | Grant from the parent to the cell |

## Verification
The bench builds two copies of the cell with the default two-stage reset synchronizer. One copy uses early release (LATE_RELEASE=0) and the other uses late release (LATE_RELEASE=1), and both are driven by the same client and parent stimulus. The difference in handover timing is therefore compared directly on the same edge.

The bench sweeps parent latencies from 0 to 2 cycles and hold times from 1 to 3 cycles for each client. Simultaneous requests are interleaved between these single-client runs, so the tie breaker is reached from both priority states. Separate sequences cover these cases:
- a request that arrives while the parent grant is still high after the cell has released;
- a reset asserted in the middle of a granted transaction.

// File: rtl/tcell_pkg.sv
package tcell_pkg;
  localparam int unsigned N_SIDES = 2;

  typedef enum logic [0:0] {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
endpackage

// File: rtl/tcell_rst_sync.sv
module tcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/tcell_uplink.sv
module tcell_uplink (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic up_gnt,
  output logic up_req
);
  logic up_req_q;
  logic up_req_d;
  logic up_en;

  always_comb begin
    up_req_d = up_req_q;
    up_en    = 1'b0;
    if (!up_req_q) begin
      // start a new round only once the previous parent grant is gone
      if (any_req && !up_gnt) begin
        up_req_d = 1'b1;
        up_en    = 1'b1;
      end
    end else if (up_gnt && !any_req) begin
      up_req_d = 1'b0;
      up_en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     up_req_q <= 1'b0;
    else if (up_en) up_req_q <= up_req_d;
  end

  assign up_req = up_req_q;
endmodule

// File: rtl/tcell_mutex.sv
module tcell_mutex
  import tcell_pkg::*;
#(
  parameter bit LATE_RELEASE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               window,
  input  logic [N_SIDES-1:0] req,
  input  logic [N_SIDES-1:0] gnt,
  output logic [N_SIDES-1:0] set
);
  side_e              favour_q;
  side_e              favour_d;
  logic               favour_en;
  logic [N_SIDES-1:0] in_cs;
  logic [N_SIDES-1:0] elig;
  logic               free;

  assign in_cs = req & gnt;
  assign free  = ~|in_cs;

  for (genvar i = 0; i < N_SIDES; i++) begin : g_elig
    logic other_clear;
    if (LATE_RELEASE) begin : g_late
      assign other_clear = ~gnt[N_SIDES-1-i];
    end else begin : g_early
      assign other_clear = 1'b1;
    end
    assign elig[i] = window & free & req[i] & ~gnt[i] & other_clear;
  end

  always_comb begin
    set[0] = elig[0] & (~elig[1] | (favour_q == SIDE_A));
    set[1] = elig[1] & (~elig[0] | (favour_q == SIDE_B));
  end

  always_comb begin
    favour_en = |set;
    favour_d  = favour_q;
    if (set[0])      favour_d = SIDE_B;
    else if (set[1]) favour_d = SIDE_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         favour_q <= SIDE_A;
    else if (favour_en) favour_q <= favour_d;
  end
endmodule

// File: rtl/tourney_cell.sv
module tourney_cell #(
  parameter bit          LATE_RELEASE = 1'b0,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  output logic gnt_a,
  input  logic req_b,
  output logic gnt_b,
  output logic up_req,
  input  logic up_gnt
);
  localparam int unsigned NS = tcell_pkg::N_SIDES;

  logic          rst_n_q;
  logic [NS-1:0] req_v;
  logic [NS-1:0] gnt_q;
  logic [NS-1:0] gnt_set;
  logic          up_req_w;

  tcell_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_q)
  );

  assign req_v = {req_b, req_a};

  tcell_uplink u_up (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .any_req (|req_v),
    .up_gnt  (up_gnt),
    .up_req  (up_req_w)
  );

  tcell_mutex #(.LATE_RELEASE(LATE_RELEASE)) u_mx (
    .clk    (clk),
    .rst_n  (rst_n_q),
    .window (up_req_w & up_gnt),
    .req    (req_v),
    .gnt    (gnt_q),
    .set    (gnt_set)
  );

  for (genvar i = 0; i < NS; i++) begin : g_gnt
    logic fall;
    logic en;
    logic d;

    always_comb begin
      fall = gnt_q[i] & ~req_v[i];
      en   = gnt_set[i] | fall;
      d    = gnt_set[i];
    end

    always_ff @(posedge clk or negedge rst_n_q) begin
      if (!rst_n_q) gnt_q[i] <= 1'b0;
      else if (en)  gnt_q[i] <= d;
    end
  end

  assign gnt_a  = gnt_q[0];
  assign gnt_b  = gnt_q[1];
  assign up_req = up_req_w;
endmodule

// File: rtl/tcell_checks.sv
module tcell_checks #(
  parameter bit LATE_RELEASE = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic req_a,
  input logic gnt_a,
  input logic req_b,
  input logic gnt_b,
  input logic up_req,
  input logic up_gnt
);
  p_cs_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !((req_a && gnt_a) && (req_b && gnt_b)));

  p_window_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_a && !(up_req && up_gnt)) |=> !gnt_a);

  p_window_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_b && !(up_req && up_gnt)) |=> !gnt_b);

  p_hold_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && req_a) |=> gnt_a);

  p_drop_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && !req_a) |=> !gnt_a);

  p_drop_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_b && !req_b) |=> !gnt_b);

  p_up_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && (req_a || req_b)) |=> up_req);

  p_up_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_req && up_gnt) |=> !up_req);

  if (LATE_RELEASE) begin : g_late
    p_gnt_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_a && gnt_b));
  end
endmodule

bind tourney_cell tcell_checks #(.LATE_RELEASE(LATE_RELEASE)) u_checks (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_a  (req_a),
  .gnt_a  (gnt_a),
  .req_b  (req_b),
  .gnt_b  (gnt_b),
  .up_req (up_req),
  .up_gnt (up_gnt)
);

// File: tb/tb_tourney_cell.sv
module tb_tourney_cell;
  logic clk;
  logic rst_n;
  logic req_a;
  logic req_b;
  logic up_gnt;
  logic e_ga, e_gb, e_up;
  logic l_ga, l_gb, l_up;
  int   n_chk;
  int   n_bad;
  bit   done;
  bit   exp_fav;   // 0: A has priority on a tie, 1: B has priority

  tourney_cell #(.LATE_RELEASE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .gnt_a(e_ga),
    .req_b(req_b), .gnt_b(e_gb), .up_req(e_up), .up_gnt(up_gnt)
  );

  tourney_cell #(.LATE_RELEASE(1'b1)) dut_late (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .gnt_a(l_ga),
    .req_b(req_b), .gnt_b(l_gb), .up_req(l_up), .up_gnt(up_gnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_req(input bit s, input logic v);
    if (s) req_b = v;
    else   req_a = v;
  endtask

  function automatic logic g_of(input bit late, input bit s);
    if (late) return s ? l_gb : l_ga;
    return s ? e_gb : e_ga;
  endfunction

  task automatic chk_both_g(input string tag, input bit s, input logic exp);
    chk({tag, " early"}, g_of(1'b0, s), exp);
    chk({tag, " late"},  g_of(1'b1, s), exp);
  endtask

  task automatic chk_up(input string tag, input logic exp);
    chk({tag, " early up_req"}, e_up, exp);
    chk({tag, " late up_req"},  l_up, exp);
  endtask

  task automatic single(input bit s, input int lat, input int hold);
    set_req(s, 1'b1);
    tick();
    chk_up("R2 raise", 1'b1);
    chk_both_g("R3 no grant before parent", s, 1'b0);
    for (int k = 0; k < lat; k++) begin
      tick();
      chk_both_g("R3 parent latency", s, 1'b0);
    end
    up_gnt = 1'b1;
    tick();
    chk_both_g("R3 grant after parent", s, 1'b1);
    chk_both_g("R4 other idle", !s, 1'b0);
    exp_fav = !s;
    for (int k = 0; k < hold; k++) begin
      tick();
      chk_both_g("R5 hold", s, 1'b1);
      chk_up("R9 keep", 1'b1);
    end
    set_req(s, 1'b0);
    tick();
    chk_both_g("R5 release", s, 1'b0);
    chk_up("R9 drop", 1'b0);
    up_gnt = 1'b0;
    tick();
  endtask

  task automatic tie();
    bit w;
    w = exp_fav;
    req_a = 1'b1;
    req_b = 1'b1;
    tick();
    chk_up("R2 tie raise", 1'b1);
    up_gnt = 1'b1;
    tick();
    chk_both_g("R8 tie winner", w, 1'b1);
    chk_both_g("R8 tie loser", !w, 1'b0);
    exp_fav = !w;
    tick();
    chk_both_g("R4 loser waits", !w, 1'b0);
    set_req(w, 1'b0);
    tick();
    chk("R6 early old grant falls", g_of(1'b0, w), 1'b0);
    chk("R6 early new grant same edge", g_of(1'b0, !w), 1'b1);
    chk("R7 late old grant falls", g_of(1'b1, w), 1'b0);
    chk("R7 late new grant waits", g_of(1'b1, !w), 1'b0);
    chk_up("R9 pending keeps up_req", 1'b1);
    tick();
    chk("R7 late new grant next edge", g_of(1'b1, !w), 1'b1);
    chk("R6 early new grant held", g_of(1'b0, !w), 1'b1);
    exp_fav = w;
    set_req(!w, 1'b0);
    tick();
    chk_both_g("R5 tie release", !w, 1'b0);
    chk_up("R9 tie drop", 1'b0);
    up_gnt = 1'b0;
    tick();
  endtask

  task automatic reraise();
    req_a = 1'b1;
    tick();
    up_gnt = 1'b1;
    tick();
    chk_both_g("R3 grant A", 1'b0, 1'b1);
    exp_fav = 1'b1;
    req_a = 1'b0;
    tick();
    chk_up("R9 drop before reraise", 1'b0);
    req_b = 1'b1;
    tick();
    chk_up("R10 hold off while parent grant high", 1'b0);
    chk_both_g("R3 no grant without up_req", 1'b1, 1'b0);
    tick();
    chk_up("R10 still held off", 1'b0);
    up_gnt = 1'b0;
    tick();
    chk_up("R10 raise after parent low", 1'b1);
    up_gnt = 1'b1;
    tick();
    chk_both_g("R3 grant B", 1'b1, 1'b1);
    exp_fav = 1'b0;
    req_b = 1'b0;
    tick();
    up_gnt = 1'b0;
    tick();
  endtask

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    done    = 1'b0;
    exp_fav = 1'b0;
    rst_n   = 1'b0;
    req_a   = 1'b0;
    req_b   = 1'b0;
    up_gnt  = 1'b0;
    tick(); tick(); tick();
    chk_both_g("R1 reset grant A", 1'b0, 1'b0);
    chk_both_g("R1 reset grant B", 1'b1, 1'b0);
    chk_up("R1 reset", 1'b0);
    rst_n = 1'b1;
    req_a = 1'b1;
    tick();
    chk_up("R1 synchronizer holds", 1'b0);
    req_a = 1'b0;
    tick(); tick(); tick();

    for (int lat = 0; lat < 3; lat++) begin
      for (int hold = 1; hold < 4; hold++) begin
        for (int s = 0; s < 2; s++) begin
          single(s[0], lat, hold);
          tie();
        end
      end
    end
    single(1'b1, 0, 1);
    tie();

    reraise();
    tie();

    req_a = 1'b1;
    tick();
    up_gnt = 1'b1;
    tick();
    chk_both_g("R3 grant before reset", 1'b0, 1'b1);
    #2;
    rst_n = 1'b0;
    #1;
    chk_both_g("R1 async clear", 1'b0, 1'b0);
    chk_up("R1 async clear", 1'b0);
    req_a  = 1'b0;
    up_gnt = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
    exp_fav = 1'b0;
    single(1'b1, 1, 1);
    tie();
    tie();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule